// File: doc/BRIEF.md
# Cartridge Bank Controller with Real-Time Clock

This block sits beside the cartridge memories on a 16-bit address bus. Writes that land in the lower half of the address space, where the ROM lives, do not reach any memory. They are decoded as control writes. These writes set an access enable, a switchable ROM bank number for the 0x4000–0x7FFF window, and a 4-bit select that gives the 0xA000–0xBFFF window either to an external RAM bank or to one register of a built-in clock.

The clock keeps seconds, minutes, hours and a 9-bit day count. It advances by one second on each cycle in which the `tick` input is high. Two flags sit in the upper day register: a halt flag that freezes counting, and a sticky flag that records a day-count overflow. Software never reads the live counters directly. A 0-then-1 write sequence to the latch range copies them into a frozen snapshot, and the window reads return that snapshot. Writes through the window, when access is enabled, load the live counters.

The block drives the RAM chip select and write enable, and it muxes the byte returned on window reads. The ROM and RAM arrays are outside the block.

Top module: `cart_bank_rtc`

## Requirements
- R1: A write to 0x0000–0x1FFF sets the access enable when data bits [3:0] equal 0xA, for example 0x0A or 0x1A. Any other low nibble clears it.
- R2: A write to 0x2000–0x3FFF loads the ROM bank from data bits [6:0]. A value of 0 is treated as 1, and the result is taken modulo ROM_BANKS.
- R3: A write to 0x4000–0x5FFF loads a 4-bit select from data bits [3:0]. A select outside 8–12 names a RAM bank. `ram_cs` is high and `ram_bank` shows that select only while access is enabled and the select is below RAM_BANKS.
- R4: Selects 8, 9, 10, 11 and 12 map the window to the clock's seconds, minutes, hours, day bits [7:0] and the upper day register. The upper day register reads as {overflow, halt, 5'b0, day bit 8}. Seconds, minutes and hours read zero-extended.
- R5: A write of 0x01 to 0x6000–0x7FFF copies the live clock into the snapshot only when the previous write to that range carried 0x00. A repeated 0x01 does not copy.
- R6: Window reads of a clock register return the snapshot, not the live value. Window writes to a clock register, with access enabled, load the live field.
- R7: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0. Each wrap carries into the next field in the same cycle. Days count from 0 to 511.
- R8: While the halt flag (upper day register bit 6) is set, `tick` does not advance the live clock.
- R9: When the day count passes 511 it returns to 0 and the overflow flag (bit 7) is set. The flag stays set until software writes the upper day register.
- R10: When access is disabled or the select is invalid, window reads return 0xFF, `ram_we` stays low, and window writes do not change the clock.
- R11: After reset the ROM bank is 1, access is disabled, the select is 0, and the live clock and snapshot are all zero.
- R12: Each cycle with `tick` high and halt clear advances the live clock by exactly one second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| tick | input | 1 | One-second advance pulse |
| ram_rdata | input | 8 | Byte from the external RAM for window reads |
| rom_bank | output | $clog2(ROM_BANKS) | Bank number for the 0x4000–0x7FFF window |
| ram_bank | output | 4 | RAM bank for the 0xA000–0xBFFF window |
| ram_cs | output | 1 | External RAM selected in the window |
| ram_we | output | 1 | Write strobe to the external RAM |
| rtc_cs | output | 1 | A clock register is selected in the window |
| win_rdata | output | 8 | Byte returned for reads of the window |

## Verification
The hardest situation to reach from the ports is the full carry chain into the sticky overflow flag. In normal running it would take 512 days of ticks to get there. The bench avoids this by loading the live counters through the window with 59 s, 59 min, 23 h, day 0xFF and upper day 0x01. A single tick then rolls every field at once, and the bench latches and reads each field back. It then checks that a further tick leaves the overflow flag set, and that the halt flag freezes the count. Because only the snapshot is visible, every observation of the live clock goes through a 0-then-1 latch sequence, and the bench also shows that a repeated 1 does not refresh the snapshot.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int unsigned SEL_W        = 4;
    localparam logic [3:0]  SEL_CLK_LO   = 4'd8;
    localparam logic [3:0]  SEL_CLK_HI   = 4'd12;
    localparam logic [3:0]  EN_KEY       = 4'hA;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hr;
        logic [8:0] day;
        logic       halt;
        logic       ovf;
    } clk_time_t;

    typedef enum logic [2:0] {
        F_SEC = 3'd0,
        F_MIN = 3'd1,
        F_HR  = 3'd2,
        F_DLO = 3'd3,
        F_DHI = 3'd4
    } clk_field_e;

    typedef enum logic [1:0] {
        CR_ENABLE = 2'd0,
        CR_ROMSEL = 2'd1,
        CR_WINSEL = 2'd2,
        CR_LATCH  = 2'd3
    } ctrl_reg_e;

    // One-second advance with the full carry chain in a single step.
    function automatic clk_time_t time_advance(clk_time_t t);
        clk_time_t n;
        logic      c_min, c_hr, c_day;
        n = t;
        if (!t.halt) begin
            c_min = (t.sec == 6'd59);
            n.sec = c_min ? 6'd0 : t.sec + 6'd1;
            c_hr  = c_min && (t.min == 6'd59);
            if (c_min) n.min = (t.min == 6'd59) ? 6'd0 : t.min + 6'd1;
            c_day = c_hr && (t.hr == 5'd23);
            if (c_hr) n.hr = (t.hr == 5'd23) ? 5'd0 : t.hr + 5'd1;
            if (c_day) begin
                n.day = t.day + 9'd1;
                if (t.day == 9'd511) n.ovf = 1'b1;
            end
        end
        return n;
    endfunction

    function automatic logic [7:0] time_read(clk_time_t t, clk_field_e f);
        logic [7:0] r;
        case (f)
            F_SEC:   r = {2'b00, t.sec};
            F_MIN:   r = {2'b00, t.min};
            F_HR:    r = {3'b000, t.hr};
            F_DLO:   r = t.day[7:0];
            F_DHI:   r = {t.ovf, t.halt, 5'b00000, t.day[8]};
            default: r = 8'hFF;
        endcase
        return r;
    endfunction

    function automatic clk_time_t time_store(clk_time_t t, clk_field_e f, logic [7:0] v);
        clk_time_t n;
        n = t;
        case (f)
            F_SEC: n.sec = v[5:0];
            F_MIN: n.min = v[5:0];
            F_HR:  n.hr  = v[4:0];
            F_DLO: n.day[7:0] = v;
            F_DHI: begin
                n.day[8] = v[0];
                n.halt   = v[6];
                n.ovf    = v[7];
            end
            default: n = t;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs
    import cbc_pkg::*;
#(
    parameter int unsigned ROM_BANKS = 128,
    localparam int unsigned ROM_W    = $clog2(ROM_BANKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [15:0]      bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic             acc_en,
    output logic [ROM_W-1:0] rom_bank,
    output logic [SEL_W-1:0] win_sel,
    output logic             latch_pulse
);
    ctrl_reg_e  creg;
    logic       ctrl_wr;
    logic [7:0] latch_prev;
    logic [6:0] bank_req;

    assign ctrl_wr  = bus_wr && !bus_addr[15];
    assign creg     = ctrl_reg_e'(bus_addr[14:13]);
    assign bank_req = (bus_wdata[6:0] == 7'd0) ? 7'd1 : bus_wdata[6:0];

    assign latch_pulse = ctrl_wr && (creg == CR_LATCH) &&
                         (bus_wdata == 8'h01) && (latch_prev == 8'h00);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_en     <= 1'b0;
            rom_bank   <= ROM_W'(1);
            win_sel    <= '0;
            latch_prev <= 8'h00;
        end else if (ctrl_wr) begin
            case (creg)
                CR_ENABLE: acc_en     <= (bus_wdata[3:0] == EN_KEY);
                CR_ROMSEL: rom_bank   <= ROM_W'(32'(bank_req) % ROM_BANKS);
                CR_WINSEL: win_sel    <= bus_wdata[SEL_W-1:0];
                CR_LATCH:  latch_prev <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // R2: the bank never leaves the populated range.
    a_r2_bank_in_range: assert property (@(posedge clk) disable iff (rst)
        32'(rom_bank) < ROM_BANKS);

    // R5: a copy needs a fresh 0 in between, so pulses never come back to back.
    a_r5_no_double_latch: assert property (@(posedge clk) disable iff (rst)
        latch_pulse |=> !latch_pulse);

endmodule

// File: rtl/cbc_win_decode.sv
module cbc_win_decode
    import cbc_pkg::*;
#(
    parameter int unsigned RAM_BANKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [15:0]      bus_addr,
    input  logic             acc_en,
    input  logic [SEL_W-1:0] win_sel,
    output logic             ram_cs,
    output logic             ram_we,
    output logic             rtc_cs,
    output logic             rtc_wr,
    output clk_field_e       field
);
    logic in_win, sel_clk, sel_ram_ok;

    assign in_win     = (bus_addr[15:13] == 3'b101);
    assign sel_clk    = (win_sel >= SEL_CLK_LO) && (win_sel <= SEL_CLK_HI);
    assign sel_ram_ok = !sel_clk && (32'(win_sel) < RAM_BANKS);

    assign ram_cs = acc_en && sel_ram_ok;
    assign rtc_cs = acc_en && sel_clk;
    assign ram_we = bus_wr && in_win && ram_cs;
    assign rtc_wr = bus_wr && in_win && rtc_cs;
    assign field  = clk_field_e'(3'(win_sel - SEL_CLK_LO));

    // R3: the window is never claimed by RAM and the clock at once.
    a_r3_cs_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ram_cs && rtc_cs));

    // R10: nothing is written while access is off.
    a_r10_no_write_disabled: assert property (@(posedge clk) disable iff (rst)
        !acc_en |-> !(ram_we || rtc_wr));

endmodule

// File: rtl/cbc_rtc_core.sv
module cbc_rtc_core
    import cbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       load,
    input  clk_field_e field,
    input  logic [7:0] wdata,
    output clk_time_t  live
);
    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
        end else if (load) begin
            live <= time_store(live, field, wdata);
        end else if (tick) begin
            live <= time_advance(live);
        end
    end

    // R7: a seconds wrap lands on zero.
    a_r7_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && !live.halt && live.sec == 6'd59) |=> live.sec == 6'd0);

    // R9: overflow is sticky against ticks.
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (live.ovf && !load) |=> live.ovf);

    // R8: a halted clock does not move.
    a_r8_halt_freeze: assert property (@(posedge clk) disable iff (rst)
        (live.halt && !load) |=> $stable(live));

endmodule

// File: rtl/cbc_rtc_latch.sv
module cbc_rtc_latch
    import cbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       latch_pulse,
    input  clk_time_t  live,
    input  clk_field_e field,
    output logic [7:0] rdata
);
    clk_time_t snap;

    always_ff @(posedge clk) begin
        if (rst)              snap <= '0;
        else if (latch_pulse) snap <= live;
    end

    assign rdata = time_read(snap, field);

    // R6: the snapshot moves only on a copy.
    a_r6_snap_hold: assert property (@(posedge clk) disable iff (rst)
        !latch_pulse |=> $stable(snap));

endmodule

// File: rtl/cart_bank_rtc.sv
module cart_bank_rtc
    import cbc_pkg::*;
#(
    parameter int unsigned ROM_BANKS = 128,
    parameter int unsigned RAM_BANKS = 4,
    localparam int unsigned ROM_W    = $clog2(ROM_BANKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [15:0]      bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             tick,
    input  logic [7:0]       ram_rdata,
    output logic [ROM_W-1:0] rom_bank,
    output logic [3:0]       ram_bank,
    output logic             ram_cs,
    output logic             ram_we,
    output logic             rtc_cs,
    output logic [7:0]       win_rdata
);
    logic             acc_en, latch_pulse, rtc_wr;
    logic [SEL_W-1:0] win_sel;
    clk_field_e       field;
    clk_time_t        live;
    logic [7:0]       clk_rdata;

    cbc_ctrl_regs #(.ROM_BANKS(ROM_BANKS)) u_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .acc_en(acc_en), .rom_bank(rom_bank),
        .win_sel(win_sel), .latch_pulse(latch_pulse)
    );

    cbc_win_decode #(.RAM_BANKS(RAM_BANKS)) u_dec (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .acc_en(acc_en), .win_sel(win_sel), .ram_cs(ram_cs), .ram_we(ram_we),
        .rtc_cs(rtc_cs), .rtc_wr(rtc_wr), .field(field)
    );

    cbc_rtc_core u_core (
        .clk(clk), .rst(rst), .tick(tick), .load(rtc_wr), .field(field),
        .wdata(bus_wdata), .live(live)
    );

    cbc_rtc_latch u_latch (
        .clk(clk), .rst(rst), .latch_pulse(latch_pulse), .live(live),
        .field(field), .rdata(clk_rdata)
    );

    assign ram_bank  = win_sel;
    assign win_rdata = ram_cs ? ram_rdata : (rtc_cs ? clk_rdata : 8'hFF);

endmodule

// File: tb/tb_cart_bank_rtc.sv
module tb_cart_bank_rtc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic        tick = 1'b0;
    logic [7:0]  ram_rdata = 8'h5A;
    logic [5:0]  rom_bank;
    logic [3:0]  ram_bank;
    logic        ram_cs, ram_we, rtc_cs;
    logic [7:0]  win_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cart_bank_rtc #(.ROM_BANKS(64), .RAM_BANKS(4)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .tick(tick), .ram_rdata(ram_rdata),
        .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_cs(ram_cs),
        .ram_we(ram_we), .rtc_cs(rtc_cs), .win_rdata(win_rdata)
    );

    // {address, data, expected bank} for ROM bank writes (R2).
    localparam logic [30:0] ROM_VEC [7] = '{
        {16'h2000, 8'h00, 7'd1},
        {16'h3FFF, 8'h05, 7'd5},
        {16'h2100, 8'h85, 7'd5},
        {16'h2000, 8'h45, 7'd5},
        {16'h2000, 8'h40, 7'd0},
        {16'h3000, 8'h3F, 7'd63},
        {16'h2000, 8'h7F, 7'd63}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 16'hA000;
        #1;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        #1;
    endtask

    task automatic snap();
        wr(16'h6000, 8'h00);
        wr(16'h6000, 8'h01);
    endtask

    task automatic rd_clk(string req, logic [3:0] s, logic [7:0] exp);
        wr(16'h4000, {4'h0, s});
        chk(req, win_rdata, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        chk("R11 rom_bank", rom_bank, 1);
        chk("R11 ram_cs", ram_cs, 0);
        chk("R11 rtc_cs", rtc_cs, 0);
        chk("R11 rd", win_rdata, 8'hFF);

        for (int i = 0; i < 7; i++) begin
            wr(ROM_VEC[i][30:15], ROM_VEC[i][14:7]);
            chk("R2 rom bank", rom_bank, 32'(ROM_VEC[i][6:0]));
        end

        // R1 enable with nibble A and upper bits set
        wr(16'h0000, 8'h1A);
        wr(16'h4000, 8'h02);
        chk("R1 ram_cs", ram_cs, 1);
        chk("R3 ram_bank", ram_bank, 2);
        chk("R3 rd ram", win_rdata, 8'h5A);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 16'hB123; #1;
        chk("R3 ram_we", ram_we, 1);
        @(negedge clk); bus_wr = 1'b0; #1;
        wr(16'h1FFF, 8'h0B);
        chk("R1 disabled cs", ram_cs, 0);
        chk("R10 disabled rd", win_rdata, 8'hFF);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 16'hA000; #1;
        chk("R10 no ram_we", ram_we, 0);
        @(negedge clk); bus_wr = 1'b0; #1;

        wr(16'h0000, 8'h0A);
        wr(16'h4000, 8'h04);
        chk("R3 invalid bank cs", ram_cs, 0);
        chk("R10 invalid rd", win_rdata, 8'hFF);
        wr(16'h5FFF, 8'h03);
        chk("R3 bank3 cs", ram_cs, 1);
        chk("R3 bank3", ram_bank, 3);

        // R6 load live seconds, read only after copy
        wr(16'h4000, 8'h08);
        chk("R4 rtc_cs", rtc_cs, 1);
        wr(16'hA000, 8'd58);
        chk("R6 snapshot before copy", win_rdata, 0);
        snap();
        chk("R5 copy sec", win_rdata, 58);
        pulse_tick(); pulse_tick();
        chk("R6 snapshot frozen", win_rdata, 58);
        snap();
        chk("R7 sec wrap", win_rdata, 0);
        rd_clk("R7 min carry", 4'd9, 1);
        // R5 repeated 1 does not copy
        pulse_tick();
        wr(16'h6000, 8'h01);
        rd_clk("R5 no copy on repeat", 4'd8, 0);
        snap();
        chk("R12 one second", win_rdata, 1);

        // R9 full carry chain
        wr(16'h4000, 8'h08); wr(16'hA000, 8'd59);
        wr(16'h4000, 8'h09); wr(16'hA000, 8'd59);
        wr(16'h4000, 8'h0A); wr(16'hA000, 8'd23);
        wr(16'h4000, 8'h0B); wr(16'hA000, 8'hFF);
        wr(16'h4000, 8'h0C); wr(16'hA000, 8'h01);
        pulse_tick();
        snap();
        rd_clk("R9 ovf set", 4'd12, 8'h80);
        rd_clk("R7 day low wrap", 4'd11, 0);
        rd_clk("R7 hr wrap", 4'd10, 0);
        rd_clk("R7 min wrap", 4'd9, 0);
        rd_clk("R7 sec wrap chain", 4'd8, 0);
        pulse_tick();
        snap();
        rd_clk("R9 ovf sticky", 4'd12, 8'h80);
        rd_clk("R12 after ovf", 4'd8, 1);

        // R8 halt
        wr(16'h4000, 8'h0C); wr(16'hA000, 8'h40);
        wr(16'h4000, 8'h08); wr(16'hA000, 8'd10);
        pulse_tick(); pulse_tick(); pulse_tick();
        snap();
        rd_clk("R8 halted sec", 4'd8, 10);
        rd_clk("R8 halt flag read", 4'd12, 8'h40);
        wr(16'hA000, 8'h00);
        pulse_tick();
        snap();
        rd_clk("R8 resumed", 4'd8, 11);

        // R10 write while disabled is ignored
        wr(16'h0000, 8'h00);
        wr(16'hA000, 8'd30);
        chk("R10 disabled clock rd", win_rdata, 8'hFF);
        wr(16'h0000, 8'h0A);
        snap();
        rd_clk("R10 clock untouched", 4'd8, 11);
        wr(16'h4000, 8'h0D);
        chk("R3 sel13 invalid", ram_cs, 0);
        chk("R10 sel13 rd", win_rdata, 8'hFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule